// File: doc/BRIEF.md
# Cache Maintenance Invalidate Dispatch Unit

This block takes one decoded system-instruction request at a time and settles the fate of a data-cache "invalidate line by address" operation. It checks the five encoding fields, then walks a fixed priority chain: privilege, hypervisor traps, fine-grained trap, watchpoint hit, write permission. It reports exactly one outcome per request. The outcomes are not-this-operation, undefined instruction, trap to level 2 with syndrome class 0x18, watchpoint exception with its cache-maintenance flag, permission fault, or a cache request.

When a cache request results, it goes to a small direct-mapped line engine. The request is a plain invalidate, or a clean-and-invalidate when level-1 code runs under active virtualization controls. The engine drops the line's valid bit. A dirty line under clean-and-invalidate is first written back on a writeback port. A fill port loads lines, and a probe port reports whether an address is currently held. These two ports let the surrounding logic and the bench see the line state.

Control is two small state machines. The dispatcher has states `T_IDLE` (accepting) and `T_BUSY` (waiting for the engine). Its transitions are `T_IDLE -> T_BUSY` on an accepted request that yields a cache request, and `T_BUSY -> T_IDLE` on `op_done`. The engine has states `E_IDLE`, `E_LOOK` and `E_WB`. Its transitions are `E_IDLE -> E_LOOK` on a command, `E_LOOK -> E_WB` on a dirty hit under clean-and-invalidate, `E_LOOK -> E_IDLE` otherwise, and `E_WB -> E_IDLE` always.

Top module: `cmo_dispatch`

## Requirements
- R1: The request is this operation only when sys_op0=1, sys_op1=0, sys_crn=7, sys_crm=6 and sys_op2=1. Any other encoding reports res_kind=0 (not matched) and starts no cache action.
- R2: A matching request at cur_el=0 reports res_kind=1 (undefined) with no cache action, whatever the other inputs are.
- R3: At cur_el=1 with el2_on=1 and hv_cmo_trap=1, the result is res_kind=2 (trap to level 2) with res_ec=0x18 and no cache action. res_ec is 0 for every other kind.
- R4: At cur_el=1 with el2_on=1, hv_fgt_inv_trap=1 also gives res_kind=2 with res_ec=0x18, but only when el3_here=0 or mon_fgt_en=1.
- R5: When no trap, watchpoint or fault applies, the cache request is clean-and-invalidate (res_kind=6) at cur_el=1 with el2_on=1 and either hv_dflt_cache or hv_s2_en set. In all other cases, including cur_el 2 and 3 where trap inputs are ignored, it is invalidate (res_kind=5).
- R6: A wp_hit that survives the privilege and trap checks reports res_kind=3 with res_cm=1 and no cache action. res_cm is 0 for every other kind.
- R7: With no watchpoint, wr_perm_ok=0 reports res_kind=4 (permission fault) and no cache action.
- R8: Each accepted request (req_valid and req_ready at a clock edge) gives one res_valid cycle right after that edge. After a cache request, req_ready stays low until op_done.
- R9: Invalidate clears the addressed line's valid bit without writeback, even when the line is dirty. op_done comes in the cycle right after acceptance.
- R10: Clean-and-invalidate on a dirty line drives wb_valid for one cycle, in the second cycle after acceptance, together with op_done. That cycle carries the 64-byte-aligned line address on wb_addr and the line's data on wb_data, and the line is then invalid. On a clean line it behaves as R9.
- R11: Any byte offset inside a line selects that line. A request whose tag misses gives op_done in the cycle after acceptance, with no writeback, and leaves the resident line valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Dispatcher can accept |
| sys_op0 | input | 2 | Encoding field op0 |
| sys_op1 | input | 3 | Encoding field op1 |
| sys_crn | input | 4 | Encoding field CRn |
| sys_crm | input | 4 | Encoding field CRm |
| sys_op2 | input | 3 | Encoding field op2 |
| req_addr | input | 64 | Operand address, any alignment |
| cur_el | input | 2 | Current privilege level |
| el2_on | input | 1 | Level 2 enabled |
| el3_here | input | 1 | Level 3 implemented |
| hv_cmo_trap | input | 1 | Hypervisor cache-maintenance trap |
| mon_fgt_en | input | 1 | Level-3 gate for fine-grained traps |
| hv_fgt_inv_trap | input | 1 | Fine-grained trap for this operation |
| hv_dflt_cache | input | 1 | Hypervisor default-cacheable control |
| hv_s2_en | input | 1 | Stage-2 translation enable |
| wr_perm_ok | input | 1 | Write permission granted by translation |
| wp_hit | input | 1 | Watchpoint matched the address |
| fill_en | input | 1 | Load a line |
| fill_addr | input | 64 | Address of line to load |
| fill_dirty | input | 1 | Loaded line is dirty |
| fill_data | input | 32 | Loaded line data |
| probe_addr | input | 64 | Address to look up |
| probe_hit | output | 1 | Probe address is resident |
| res_valid | output | 1 | Outcome valid |
| res_kind | output | 3 | Outcome code (see R1 to R7) |
| res_ec | output | 6 | Syndrome class for traps |
| res_cm | output | 1 | Cache-maintenance flag for watchpoints |
| wb_valid | output | 1 | Writeback beat |
| wb_addr | output | 64 | Line-aligned writeback address |
| wb_data | output | 32 | Writeback data |
| op_done | output | 1 | Cache request finished |

## Verification
The main sweep covers every combination of the four privilege levels and the nine control inputs (2048 patterns). This shows whether each priority step wins over the later ones, and whether trap inputs are ignored at levels 0, 2 and 3. The dirty bit of the targeted line alternates and the byte offset varies across the sweep, which separates invalidate from clean-and-invalidate by the presence of a writeback and confirms that unaligned addresses reach the right line. A separate sweep changes each encoding field through all its values with the others held, to show that only the exact encoding is recognised. A tag-mismatch request on an occupied index separates a miss from a hit.

// File: rtl/cmo_pkg.sv
package cmo_pkg;

    typedef enum logic [2:0] {
        K_NOMATCH = 3'd0,
        K_UNDEF   = 3'd1,
        K_TRAP    = 3'd2,
        K_WATCH   = 3'd3,
        K_PERM    = 3'd4,
        K_INV     = 3'd5,
        K_CINV    = 3'd6
    } cmo_kind_t;

    localparam logic [5:0] TRAP_EC   = 6'h18;

    localparam logic [1:0] ENC_OP0 = 2'b01;
    localparam logic [2:0] ENC_OP1 = 3'b000;
    localparam logic [3:0] ENC_CRN = 4'b0111;
    localparam logic [3:0] ENC_CRM = 4'b0110;
    localparam logic [2:0] ENC_OP2 = 3'b001;

endpackage

// File: rtl/cmo_decode.sv
module cmo_decode
    import cmo_pkg::*;
(
    input  logic [1:0] sys_op0,
    input  logic [2:0] sys_op1,
    input  logic [3:0] sys_crn,
    input  logic [3:0] sys_crm,
    input  logic [2:0] sys_op2,
    input  logic [1:0] cur_el,
    input  logic       el2_on,
    input  logic       el3_here,
    input  logic       hv_cmo_trap,
    input  logic       mon_fgt_en,
    input  logic       hv_fgt_inv_trap,
    input  logic       hv_dflt_cache,
    input  logic       hv_s2_en,
    input  logic       wr_perm_ok,
    input  logic       wp_hit,
    output cmo_kind_t  kind
);

    logic enc_match;
    logic at_el1_virt;
    logic fgt_live;
    logic escalate;

    assign enc_match = (sys_op0 == ENC_OP0) && (sys_op1 == ENC_OP1) &&
                       (sys_crn == ENC_CRN) && (sys_crm == ENC_CRM) &&
                       (sys_op2 == ENC_OP2);

    // Level-1 code running beneath an enabled level 2.
    assign at_el1_virt = (cur_el == 2'd1) && el2_on;
    // Fine-grained trap only counts when level 3 permits it or is absent.
    assign fgt_live    = hv_fgt_inv_trap && (!el3_here || mon_fgt_en);
    assign escalate    = at_el1_virt && (hv_dflt_cache || hv_s2_en);

    always_comb begin
        if (!enc_match) begin
            kind = K_NOMATCH;
        end else if (cur_el == 2'd0) begin
            kind = K_UNDEF;
        end else if (at_el1_virt && hv_cmo_trap) begin
            kind = K_TRAP;
        end else if (at_el1_virt && fgt_live) begin
            kind = K_TRAP;
        end else if (wp_hit) begin
            kind = K_WATCH;
        end else if (!wr_perm_ok) begin
            kind = K_PERM;
        end else if (escalate) begin
            kind = K_CINV;
        end else begin
            kind = K_INV;
        end
    end

endmodule

// File: rtl/cmo_line_engine.sv
module cmo_line_engine #(
    parameter int ADDR_W     = 64,
    parameter int LINE_BYTES = 64,
    parameter int NUM_LINES  = 4,
    parameter int DATA_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_clean,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              fill_en,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_dirty,
    input  logic [DATA_W-1:0] fill_data,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              probe_hit,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data,
    output logic              done
);

    localparam int OFS_W = $clog2(LINE_BYTES);
    localparam int IDX_W = $clog2(NUM_LINES);
    localparam int TAG_W = ADDR_W - OFS_W - IDX_W;
    localparam int LA_W  = ADDR_W - OFS_W;

    typedef enum logic [1:0] {
        E_IDLE = 2'd0,
        E_LOOK = 2'd1,
        E_WB   = 2'd2
    } eng_state_t;

    eng_state_t state_q, state_d;

    logic [LA_W-1:0]   line_q;
    logic              clean_q;
    logic [NUM_LINES-1:0] valid_q;
    logic [NUM_LINES-1:0] dirty_q;
    logic [TAG_W-1:0]  tag_q  [NUM_LINES];
    logic [DATA_W-1:0] data_q [NUM_LINES];

    logic [IDX_W-1:0]  cur_idx;
    logic [TAG_W-1:0]  cur_tag;
    logic              cur_hit;
    logic              need_wb;
    logic              clear_en;
    logic [IDX_W-1:0]  fill_idx;
    logic [IDX_W-1:0]  probe_idx;
    logic              unused_ofs;

    assign unused_ofs = ^{cmd_addr[OFS_W-1:0], fill_addr[OFS_W-1:0],
                          probe_addr[OFS_W-1:0]};

    assign cur_idx   = line_q[IDX_W-1:0];
    assign cur_tag   = line_q[LA_W-1:IDX_W];
    assign cur_hit   = valid_q[cur_idx] && (tag_q[cur_idx] == cur_tag);
    assign need_wb   = cur_hit && clean_q && dirty_q[cur_idx];
    assign fill_idx  = fill_addr[OFS_W +: IDX_W];
    assign probe_idx = probe_addr[OFS_W +: IDX_W];
    assign probe_hit = valid_q[probe_idx] &&
                       (tag_q[probe_idx] == probe_addr[ADDR_W-1 -: TAG_W]);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= E_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            E_IDLE: if (cmd_valid) state_d = E_LOOK;
            E_LOOK: state_d = need_wb ? E_WB : E_IDLE;
            E_WB:   state_d = E_IDLE;
            default: state_d = E_IDLE;
        endcase
    end

    // Outputs decoded from state.
    always_comb begin
        cmd_ready = 1'b0;
        done      = 1'b0;
        wb_valid  = 1'b0;
        clear_en  = 1'b0;
        unique case (state_q)
            E_IDLE: cmd_ready = 1'b1;
            E_LOOK: begin
                done     = !need_wb;
                clear_en = cur_hit && !need_wb;
            end
            E_WB: begin
                done     = 1'b1;
                wb_valid = 1'b1;
                clear_en = cur_hit;
            end
            default: ;
        endcase
    end

    assign wb_addr = {line_q, {OFS_W{1'b0}}};
    assign wb_data = data_q[cur_idx];

    // Command capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q  <= '0;
            clean_q <= 1'b0;
        end else if (state_q == E_IDLE && cmd_valid) begin
            line_q  <= cmd_addr[ADDR_W-1:OFS_W];
            clean_q <= cmd_clean;
        end
    end

    // Per-line status bits; a clear wins over a fill to the same slot.
    generate
        for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    valid_q[g] <= 1'b0;
                    dirty_q[g] <= 1'b0;
                end else if (clear_en && cur_idx == IDX_W'(g)) begin
                    valid_q[g] <= 1'b0;
                    dirty_q[g] <= 1'b0;
                end else if (fill_en && fill_idx == IDX_W'(g)) begin
                    valid_q[g] <= 1'b1;
                    dirty_q[g] <= fill_dirty;
                end
            end

            always_ff @(posedge clk) begin
                if (fill_en && fill_idx == IDX_W'(g)) begin
                    tag_q[g]  <= fill_addr[ADDR_W-1 -: TAG_W];
                    data_q[g] <= fill_data;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/cmo_dispatch.sv
module cmo_dispatch
    import cmo_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int LINE_BYTES = 64,
    parameter int NUM_LINES  = 4,
    parameter int DATA_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        sys_op0,
    input  logic [2:0]        sys_op1,
    input  logic [3:0]        sys_crn,
    input  logic [3:0]        sys_crm,
    input  logic [2:0]        sys_op2,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        cur_el,
    input  logic              el2_on,
    input  logic              el3_here,
    input  logic              hv_cmo_trap,
    input  logic              mon_fgt_en,
    input  logic              hv_fgt_inv_trap,
    input  logic              hv_dflt_cache,
    input  logic              hv_s2_en,
    input  logic              wr_perm_ok,
    input  logic              wp_hit,
    input  logic              fill_en,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_dirty,
    input  logic [DATA_W-1:0] fill_data,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              probe_hit,
    output logic              res_valid,
    output logic [2:0]        res_kind,
    output logic [5:0]        res_ec,
    output logic              res_cm,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data,
    output logic              op_done
);

    typedef enum logic {
        T_IDLE = 1'b0,
        T_BUSY = 1'b1
    } top_state_t;

    top_state_t tstate_q, tstate_d;
    cmo_kind_t  dec_kind;
    cmo_kind_t  kind_q;
    logic       res_valid_q;
    logic       accept;
    logic       is_cache_op;
    logic       eng_ready;
    logic       eng_done;

    cmo_decode u_dec (
        .sys_op0         (sys_op0),
        .sys_op1         (sys_op1),
        .sys_crn         (sys_crn),
        .sys_crm         (sys_crm),
        .sys_op2         (sys_op2),
        .cur_el          (cur_el),
        .el2_on          (el2_on),
        .el3_here        (el3_here),
        .hv_cmo_trap     (hv_cmo_trap),
        .mon_fgt_en      (mon_fgt_en),
        .hv_fgt_inv_trap (hv_fgt_inv_trap),
        .hv_dflt_cache   (hv_dflt_cache),
        .hv_s2_en        (hv_s2_en),
        .wr_perm_ok      (wr_perm_ok),
        .wp_hit          (wp_hit),
        .kind            (dec_kind)
    );

    assign req_ready   = (tstate_q == T_IDLE) && eng_ready;
    assign accept      = req_valid && req_ready;
    assign is_cache_op = (dec_kind == K_INV) || (dec_kind == K_CINV);

    cmo_line_engine #(
        .ADDR_W     (ADDR_W),
        .LINE_BYTES (LINE_BYTES),
        .NUM_LINES  (NUM_LINES),
        .DATA_W     (DATA_W)
    ) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (accept && is_cache_op),
        .cmd_ready  (eng_ready),
        .cmd_clean  (dec_kind == K_CINV),
        .cmd_addr   (req_addr),
        .fill_en    (fill_en),
        .fill_addr  (fill_addr),
        .fill_dirty (fill_dirty),
        .fill_data  (fill_data),
        .probe_addr (probe_addr),
        .probe_hit  (probe_hit),
        .wb_valid   (wb_valid),
        .wb_addr    (wb_addr),
        .wb_data    (wb_data),
        .done       (eng_done)
    );

    assign op_done = eng_done;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tstate_q <= T_IDLE;
        end else begin
            tstate_q <= tstate_d;
        end
    end

    // Next-state selection.
    always_comb begin
        tstate_d = tstate_q;
        unique case (tstate_q)
            T_IDLE: if (accept && is_cache_op) tstate_d = T_BUSY;
            T_BUSY: if (eng_done) tstate_d = T_IDLE;
            default: tstate_d = T_IDLE;
        endcase
    end

    // Registered outcome report.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid_q <= 1'b0;
            kind_q      <= K_NOMATCH;
        end else begin
            res_valid_q <= accept;
            if (accept) begin
                kind_q <= dec_kind;
            end
        end
    end

    assign res_valid = res_valid_q;
    assign res_kind  = res_valid_q ? kind_q : K_NOMATCH;
    assign res_ec    = (res_valid_q && kind_q == K_TRAP) ? TRAP_EC : 6'd0;
    assign res_cm    = res_valid_q && (kind_q == K_WATCH);

endmodule

// File: rtl/cmo_dispatch_chk.sv
module cmo_dispatch_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic [1:0] sys_op0,
    input logic [2:0] sys_op1,
    input logic [3:0] sys_crn,
    input logic [3:0] sys_crm,
    input logic [2:0] sys_op2,
    input logic [1:0] cur_el,
    input logic       res_valid,
    input logic [2:0] res_kind,
    input logic [5:0] res_ec,
    input logic       res_cm,
    input logic       wb_valid,
    input logic       op_done
);

    logic enc_ok;
    assign enc_ok = sys_op0 == 2'd1 && sys_op1 == 3'd0 && sys_crn == 4'd7 &&
                    sys_crm == 4'd6 && sys_op2 == 3'd1;

    a_r8_one_report: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> res_valid);

    a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (res_kind == 3'd5 || res_kind == 3'd6)) |-> !req_ready);

    a_r2_level0_undef: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && enc_ok && cur_el == 2'd0) |=> res_kind == 3'd1);

    a_r1_nomatch: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !enc_ok) |=> res_kind == 3'd0);

    a_r3_trap_class: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_kind == 3'd2) |-> res_ec == 6'h18);

    a_r3_class_only_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (res_ec != 6'd0) |-> (res_valid && res_kind == 3'd2));

    a_r6_cm_watch: assert property (@(posedge clk) disable iff (!rst_n)
        res_cm |-> (res_valid && res_kind == 3'd3));

    a_r9_inv_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_kind == 3'd5) |=> !wb_valid);

    a_r10_wb_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> op_done);

    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !op_done);

endmodule

bind cmo_dispatch cmo_dispatch_chk u_chk (.*);

// File: tb/sim_cmo_dispatch.sv
`timescale 1ns/1ps
module sim_cmo_dispatch;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  sys_op0 = 2'd1;
    logic [2:0]  sys_op1 = 3'd0;
    logic [3:0]  sys_crn = 4'd7;
    logic [3:0]  sys_crm = 4'd6;
    logic [2:0]  sys_op2 = 3'd1;
    logic [63:0] req_addr = '0;
    logic [1:0]  cur_el = 2'd2;
    logic        el2_on = 0, el3_here = 0, hv_cmo_trap = 0, mon_fgt_en = 0;
    logic        hv_fgt_inv_trap = 0, hv_dflt_cache = 0, hv_s2_en = 0;
    logic        wr_perm_ok = 1, wp_hit = 0;
    logic        fill_en = 0, fill_dirty = 0;
    logic [63:0] fill_addr = '0, probe_addr = '0;
    logic [31:0] fill_data = '0;
    logic        probe_hit, res_valid, res_cm, wb_valid, op_done;
    logic [2:0]  res_kind;
    logic [5:0]  res_ec;
    logic [63:0] wb_addr;
    logic [31:0] wb_data;

    always #2 clk = ~clk;

    cmo_dispatch u0 (.*);

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // observation results of one request
    logic       o_valid, o_cm, o_ready;
    logic [2:0] o_kind;
    logic [5:0] o_ec;
    int         o_done_cnt, o_done_at, o_wb_cnt, o_wb_at;
    logic [63:0] o_wb_addr;
    logic [31:0] o_wb_data;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic fill(input logic [63:0] a, input bit d, input logic [31:0] v);
        @(negedge clk);
        fill_en = 1; fill_addr = a; fill_dirty = d; fill_data = v;
        @(negedge clk);
        fill_en = 0;
    endtask

    task automatic issue(input logic [63:0] a);
        @(negedge clk);
        req_addr = a;
        req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        o_valid = res_valid; o_kind = res_kind; o_ec = res_ec; o_cm = res_cm;
        o_ready = req_ready;
        o_done_cnt = 0; o_wb_cnt = 0; o_done_at = -1; o_wb_at = -1;
        o_wb_addr = '0; o_wb_data = '0;
        for (int c = 0; c < 4; c++) begin
            if (c > 0) @(negedge clk);
            if (op_done) begin
                if (o_done_cnt == 0) o_done_at = c;
                o_done_cnt++;
            end
            if (wb_valid) begin
                if (o_wb_cnt == 0) o_wb_at = c;
                o_wb_cnt++;
                o_wb_addr = wb_addr; o_wb_data = wb_data;
            end
        end
    endtask

    // Expected outcome from the requirements (R2..R7).
    function automatic logic [2:0] expect_kind(
        input logic [1:0] el, input bit e2, input bit e3, input bit tp,
        input bit fe, input bit fb, input bit dc, input bit vm,
        input bit wp, input bit pm);
        bit v1;
        v1 = (el == 2'd1) && e2;
        if (el == 2'd0) return 3'd1;
        if (v1 && tp) return 3'd2;
        if (v1 && fb && (!e3 || fe)) return 3'd2;
        if (wp) return 3'd3;
        if (!pm) return 3'd4;
        if (v1 && (dc || vm)) return 3'd6;
        return 3'd5;
    endfunction

    function automatic string tag_of(input logic [2:0] k);
        case (k)
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R6";
            3'd4: return "R7";
            default: return "R5";
        endcase
    endfunction

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] la, a;
        logic [31:0] dv;
        logic [2:0]  ek;
        bit          dty;

        repeat (3) @(negedge clk);
        // reset state (R8)
        chk(res_valid == 0, "R8 reset res_valid", res_valid, 0);
        chk(op_done == 0 && wb_valid == 0, "R10 reset wb/done", {op_done, wb_valid}, 0);
        chk(probe_hit == 0, "R11 reset probe", probe_hit, 0);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready == 1, "R8 ready after reset", req_ready, 1);

        // Exhaustive sweep over privilege level and control inputs.
        for (int i = 0; i < 2048; i++) begin
            cur_el = i[1:0];
            el2_on = i[2]; el3_here = i[3]; hv_cmo_trap = i[4]; mon_fgt_en = i[5];
            hv_fgt_inv_trap = i[6]; hv_dflt_cache = i[7]; hv_s2_en = i[8];
            wp_hit = i[9]; wr_perm_ok = i[10];
            la  = 64'h0000_7A50_0000_0000 + 64'(i) * 64;
            a   = la + 64'(i % 64);
            dv  = 32'(i) * 32'h9E37_79B1 + 32'h55;
            dty = i[0] ^ i[7] ^ i[8];
            fill(la, dty, dv);
            probe_addr = a;
            ek = expect_kind(i[1:0], i[2], i[3], i[4], i[5], i[6], i[7], i[8], i[9], i[10]);
            issue(a);
            chk(o_valid == 1, "R8 res_valid", o_valid, 1);
            chk(o_kind == ek, tag_of(ek), o_kind, ek);
            chk(o_ec == ((ek == 3'd2) ? 6'h18 : 6'd0), "R4 syndrome class", o_ec,
                (ek == 3'd2) ? 6'h18 : 6'd0);
            chk(o_cm == (ek == 3'd3), "R6 cm flag", o_cm, ek == 3'd3);
            if (ek == 3'd5 || ek == 3'd6) begin
                chk(o_ready == 0, "R8 busy ready", o_ready, 0);
                if (ek == 3'd6 && dty) begin
                    chk(o_done_at == 1 && o_done_cnt == 1, "R10 done timing", o_done_at, 1);
                    chk(o_wb_cnt == 1 && o_wb_at == 1, "R10 wb beat", o_wb_cnt, 1);
                    chk(o_wb_addr == la, "R10 wb addr", o_wb_addr, la);
                    chk(o_wb_data == dv, "R10 wb data", o_wb_data, dv);
                end else begin
                    chk(o_done_at == 0 && o_done_cnt == 1, "R9 done timing", o_done_at, 0);
                    chk(o_wb_cnt == 0, "R9 no writeback", o_wb_cnt, 0);
                end
                chk(probe_hit == 0, "R11 line gone", probe_hit, 0);
            end else begin
                chk(o_done_cnt == 0 && o_wb_cnt == 0, {tag_of(ek), " no action"},
                    o_done_cnt + o_wb_cnt, 0);
                chk(probe_hit == 1, {tag_of(ek), " line kept"}, probe_hit, 1);
            end
        end

        // Encoding sweep: one field varied at a time (R1).
        cur_el = 2'd2; wp_hit = 0; wr_perm_ok = 1;
        for (int f = 0; f < 5; f++) begin
            for (int v = 0; v < 16; v++) begin
                bit m;
                if ((f == 0 && v >= 4) || ((f == 1 || f == 4) && v >= 8)) continue;
                sys_op0 = 2'd1; sys_op1 = 3'd0; sys_crn = 4'd7; sys_crm = 4'd6; sys_op2 = 3'd1;
                case (f)
                    0: sys_op0 = 2'(v);
                    1: sys_op1 = 3'(v);
                    2: sys_crn = 4'(v);
                    3: sys_crm = 4'(v);
                    default: sys_op2 = 3'(v);
                endcase
                m = (sys_op0 == 2'd1 && sys_op1 == 3'd0 && sys_crn == 4'd7 &&
                     sys_crm == 4'd6 && sys_op2 == 3'd1);
                la = 64'h0000_0BAD_0000_1000 + 64'(v) * 64;
                fill(la, 1'b1, 32'(v + 100 * f));
                probe_addr = la;
                issue(la + 64'd5);
                chk(o_kind == (m ? 3'd5 : 3'd0), "R1 encoding", o_kind, m ? 3'd5 : 3'd0);
                chk(probe_hit == !m, "R1 line state", probe_hit, !m);
                chk(o_done_cnt == (m ? 1 : 0), "R1 cache action", o_done_cnt, m ? 1 : 0);
            end
        end
        sys_op0 = 2'd1; sys_op1 = 3'd0; sys_crn = 4'd7; sys_crm = 4'd6; sys_op2 = 3'd1;

        // Tag miss on an occupied index (R11).
        cur_el = 2'd1; el2_on = 1; hv_cmo_trap = 0; hv_fgt_inv_trap = 0;
        hv_s2_en = 1; hv_dflt_cache = 0;
        la = 64'h0000_0000_CAFE_0080;
        fill(la, 1'b1, 32'hDEAD_BEEF);
        probe_addr = la;
        issue(64'h0000_0001_CAFE_00BF);
        chk(o_kind == 3'd6, "R11 miss kind", o_kind, 6);
        chk(o_done_at == 0 && o_done_cnt == 1, "R11 miss done timing", o_done_at, 0);
        chk(o_wb_cnt == 0, "R11 miss no writeback", o_wb_cnt, 0);
        chk(probe_hit == 1, "R11 resident line kept", probe_hit, 1);
        // Same line, last byte offset: hits and writes back (R10).
        issue(la + 64'd63);
        chk(o_wb_cnt == 1 && o_wb_addr == la, "R10 last-offset writeback", o_wb_addr, la);
        chk(probe_hit == 0, "R10 line invalid after", probe_hit, 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule